// File: doc/BRIEF.md
# Three-Dimensional Transfer Address Generator

This block turns one set of transfer parameters into the ordered stream of byte addresses that a DMA engine reads from and writes to. A transfer is a block made of frames, each frame made of arrays, each array made of bytes. The source and destination sides each have their own base address, a signed stride between array starts, and a signed stride between frame starts. Either side can also be pinned to one fixed address, which suits a peripheral data register.

Parameters are captured with a one-cycle load strobe. After that, the block waits for synchronization events. In the array-granular mode each event releases one array. In the frame-granular mode each event releases a whole frame. Each beat on the output carries one source address and one destination address, and is handed over with a valid/ready handshake. The last beat of an event and the last beat of the block are flagged. An event that arrives while another is being served is remembered and served next. Moving the data and chaining to further parameter sets are left to the surrounding engine.

Top module: `xfer_addr_gen`

## Requirements
- R1: After reset, `out_valid` and `busy` are low.
- R2: A load strobe captures all parameters and sets `busy`. No beat is offered until a synchronization event arrives, and the first beat carries the two base addresses. `ld_size_count` holds bytes per array in bits [15:0] and arrays per frame in bits [31:16].
- R3: Within an array, each accepted beat advances a non-fixed address by one byte, and an array holds exactly bytes-per-array beats.
- R4: Each new array within a frame starts at the previous array start plus the signed array stride. In both stride words the source stride is in bits [15:0] and the destination stride in bits [31:16]. A stride of zero restarts the same addresses.
- R5: In frame-granular mode (`ld_frame_sync`=1), one event releases a whole frame. `out_evt_end` is high only on the frame's last byte. The next frame starts at the previous frame start plus the signed frame stride, and every frame uses the loaded array count.
- R6: In array-granular mode (`ld_frame_sync`=0), one event releases one array and `out_evt_end` is high on each array's last byte. When a frame completes, the next array starts at the last array start plus the frame stride.
- R7: In array-granular mode, the first frame uses the loaded array count and every later frame uses the reload count `ld_reload`.
- R8: `out_blk_end` is high, together with `out_evt_end`, only on the last byte of the last array of the last frame. After it is accepted, `busy` and `out_valid` are low and events are ignored until the next load.
- R9: An event that arrives while a beat sequence is in progress is held in a single pending flag and starts the next event without a further strobe.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_src` and `out_dst` hold their values.
- R11: A side whose fixed flag was loaded high presents its base address on every beat of the block, regardless of strides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Parameter load strobe; also aborts any transfer in progress |
| ld_src_base | input | AW | Source start address |
| ld_dst_base | input | AW | Destination start address |
| ld_size_count | input | 2*CW | [15:0] bytes per array, [31:16] arrays per frame |
| ld_frames | input | CW | Frames per block |
| ld_reload | input | CW | Array count for later frames in array-granular mode |
| ld_arr_stride | input | 2*IW | Signed array strides: [15:0] source, [31:16] destination |
| ld_frm_stride | input | 2*IW | Signed frame strides: [15:0] source, [31:16] destination |
| ld_frame_sync | input | 1 | 1: one event per frame; 0: one event per array |
| ld_src_fixed | input | 1 | Hold source address at its base |
| ld_dst_fixed | input | 1 | Hold destination address at its base |
| sync_evt | input | 1 | Synchronization event pulse |
| out_ready | input | 1 | Consumer accepts the current beat |
| out_valid | output | 1 | A beat is offered |
| out_src | output | AW | Source byte address of the beat |
| out_dst | output | AW | Destination byte address of the beat |
| out_evt_end | output | 1 | Beat is the last of the current event |
| out_blk_end | output | 1 | Beat is the last of the block |
| busy | output | 1 | Parameters loaded and block not yet finished |

## Verification
The hardest case to reach is the pending-event path. A strobe must land while a frame is still streaming, so that the next frame starts with no strobe after the end-of-event beat. The stimulus raises the strobe during the first beat of a frame and then withholds the strobe it would normally give for the following frame. Checking the walk with frame strides, and not only with array strides, also needs multi-frame blocks in both modes. These use negative strides, and a reload count that differs from the loaded array count.

// File: rtl/agen_pkg.sv
package agen_pkg;

    typedef enum logic [2:0] {
        WK_HOLD,
        WK_LOAD,
        WK_BYTE,
        WK_ARRAY,
        WK_FRAME_AB,
        WK_FRAME_A
    } walk_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RUN
    } seq_state_e;

endpackage

// File: rtl/agen_walk.sv
module agen_walk
    import agen_pkg::*;
#(
    parameter int AW = 32,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  walk_cmd_e     cmd_i,
    input  logic [AW-1:0] base_i,
    input  logic          fixed_i,
    input  logic [IW-1:0] arr_stride_i,
    input  logic [IW-1:0] frm_stride_i,
    output logic [AW-1:0] addr_o
);

    localparam int EXT = AW - IW;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] arr;
        logic [AW-1:0] frm;
    } walk_t;

    walk_t st_d, st_q;
    logic [AW-1:0] arr_step, frm_step, nxt;

    assign arr_step = {{EXT{arr_stride_i[IW-1]}}, arr_stride_i};
    assign frm_step = {{EXT{frm_stride_i[IW-1]}}, frm_stride_i};

    always_comb begin
        st_d = st_q;
        nxt  = st_q.addr;
        case (cmd_i)
            WK_LOAD: begin
                st_d.addr = base_i;
                st_d.arr  = base_i;
                st_d.frm  = base_i;
            end
            WK_BYTE: begin
                if (!fixed_i) st_d.addr = st_q.addr + 1'b1;
            end
            WK_ARRAY: begin
                if (!fixed_i) begin
                    nxt       = st_q.arr + arr_step;
                    st_d.addr = nxt;
                    st_d.arr  = nxt;
                end
            end
            WK_FRAME_AB: begin
                if (!fixed_i) begin
                    nxt       = st_q.frm + frm_step;
                    st_d.addr = nxt;
                    st_d.arr  = nxt;
                    st_d.frm  = nxt;
                end
            end
            WK_FRAME_A: begin
                if (!fixed_i) begin
                    nxt       = st_q.arr + frm_step;
                    st_d.addr = nxt;
                    st_d.arr  = nxt;
                    st_d.frm  = nxt;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o = st_q.addr;

    p_byte_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == WK_BYTE && !fixed_i) |=> addr_o == $past(addr_o) + 1'b1);

    p_fixed_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fixed_i && cmd_i != WK_LOAD) |=> addr_o == $past(addr_o));

endmodule

// File: rtl/agen_seq.sv
module agen_seq
    import agen_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [CW-1:0] ld_acnt,
    input  logic [CW-1:0] ld_bcnt,
    input  logic [CW-1:0] ld_ccnt,
    input  logic [CW-1:0] ld_rld,
    input  logic          ld_absync,
    input  logic          sync_evt,
    input  logic          out_ready,
    output logic          out_valid,
    output logic          evt_end,
    output logic          blk_end,
    output logic          busy,
    output walk_cmd_e     cmd
);

    typedef struct packed {
        seq_state_e    state;
        logic          pend;
        logic [CW-1:0] a_left;
        logic [CW-1:0] b_left;
        logic [CW-1:0] c_left;
        logic [CW-1:0] acnt;
        logic [CW-1:0] bcnt;
        logic [CW-1:0] rld;
        logic          absync;
    } seq_t;

    seq_t sq_d, sq_q;
    logic last_byte, last_arr, last_frm, fire;

    assign last_byte = (sq_q.a_left == CW'(1));
    assign last_arr  = (sq_q.b_left == CW'(1));
    assign last_frm  = (sq_q.c_left == CW'(1));
    assign out_valid = (sq_q.state == ST_RUN);
    assign fire      = out_valid && out_ready;
    assign evt_end   = out_valid && last_byte && (!sq_q.absync || last_arr);
    assign blk_end   = out_valid && last_byte && last_arr && last_frm;
    assign busy      = (sq_q.state != ST_IDLE);

    always_comb begin
        sq_d = sq_q;
        cmd  = WK_HOLD;
        case (sq_q.state)
            ST_IDLE: sq_d.pend = 1'b0;
            ST_WAIT: begin
                if (sync_evt || sq_q.pend) begin
                    sq_d.state = ST_RUN;
                    sq_d.pend  = 1'b0;
                end
            end
            ST_RUN: begin
                sq_d.pend = sq_q.pend | sync_evt;
                if (fire) begin
                    if (!last_byte) begin
                        cmd         = WK_BYTE;
                        sq_d.a_left = sq_q.a_left - 1'b1;
                    end else if (!last_arr) begin
                        cmd         = WK_ARRAY;
                        sq_d.a_left = sq_q.acnt;
                        sq_d.b_left = sq_q.b_left - 1'b1;
                        if (!sq_q.absync) sq_d.state = ST_WAIT;
                    end else if (!last_frm) begin
                        cmd         = sq_q.absync ? WK_FRAME_AB : WK_FRAME_A;
                        sq_d.a_left = sq_q.acnt;
                        sq_d.b_left = sq_q.absync ? sq_q.bcnt : sq_q.rld;
                        sq_d.c_left = sq_q.c_left - 1'b1;
                        sq_d.state  = ST_WAIT;
                    end else begin
                        sq_d.state = ST_IDLE;
                        sq_d.pend  = 1'b0;
                    end
                end
            end
            default: sq_d.state = ST_IDLE;
        endcase
        if (ld_en) begin
            cmd         = WK_LOAD;
            sq_d.state  = ST_WAIT;
            sq_d.pend   = 1'b0;
            sq_d.acnt   = ld_acnt;
            sq_d.bcnt   = ld_bcnt;
            sq_d.rld    = ld_rld;
            sq_d.absync = ld_absync;
            sq_d.a_left = ld_acnt;
            sq_d.b_left = ld_bcnt;
            sq_d.c_left = ld_ccnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    p_blk_has_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        blk_end |-> evt_end);

    p_byte_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !last_byte && !ld_en) |=> sq_q.a_left == $past(sq_q.a_left) - 1'b1);

    p_pend_served_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.state == ST_WAIT && sq_q.pend && !ld_en) |=> out_valid);

endmodule

// File: rtl/xfer_addr_gen.sv
module xfer_addr_gen
    import agen_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int IW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_en,
    input  logic [AW-1:0]   ld_src_base,
    input  logic [AW-1:0]   ld_dst_base,
    input  logic [2*CW-1:0] ld_size_count,
    input  logic [CW-1:0]   ld_frames,
    input  logic [CW-1:0]   ld_reload,
    input  logic [2*IW-1:0] ld_arr_stride,
    input  logic [2*IW-1:0] ld_frm_stride,
    input  logic            ld_frame_sync,
    input  logic            ld_src_fixed,
    input  logic            ld_dst_fixed,
    input  logic            sync_evt,
    input  logic            out_ready,
    output logic            out_valid,
    output logic [AW-1:0]   out_src,
    output logic [AW-1:0]   out_dst,
    output logic            out_evt_end,
    output logic            out_blk_end,
    output logic            busy
);

    localparam int NSIDE = 2;

    typedef struct packed {
        logic [2*IW-1:0]  arr_stride;
        logic [2*IW-1:0]  frm_stride;
        logic [NSIDE-1:0] fixed;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    walk_cmd_e cmd;
    logic [AW-1:0] base_w [NSIDE];
    logic [AW-1:0] addr_w [NSIDE];

    always_comb begin
        cfg_d = cfg_q;
        if (ld_en) begin
            cfg_d.arr_stride = ld_arr_stride;
            cfg_d.frm_stride = ld_frm_stride;
            cfg_d.fixed      = {ld_dst_fixed, ld_src_fixed};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign base_w[0] = ld_src_base;
    assign base_w[1] = ld_dst_base;

    agen_seq #(.CW(CW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (ld_en),
        .ld_acnt   (ld_size_count[CW-1:0]),
        .ld_bcnt   (ld_size_count[2*CW-1:CW]),
        .ld_ccnt   (ld_frames),
        .ld_rld    (ld_reload),
        .ld_absync (ld_frame_sync),
        .sync_evt  (sync_evt),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .evt_end   (out_evt_end),
        .blk_end   (out_blk_end),
        .busy      (busy),
        .cmd       (cmd)
    );

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        agen_walk #(.AW(AW), .IW(IW)) u_walk (
            .clk          (clk),
            .rst_n        (rst_n),
            .cmd_i        (cmd),
            .base_i       (base_w[g]),
            .fixed_i      (cfg_q.fixed[g]),
            .arr_stride_i (cfg_q.arr_stride[g*IW +: IW]),
            .frm_stride_i (cfg_q.frm_stride[g*IW +: IW]),
            .addr_o       (addr_w[g])
        );
    end

    assign out_src = addr_w[0];
    assign out_dst = addr_w[1];

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !ld_en)
        |=> out_valid && $stable(out_src) && $stable(out_dst));

    p_idle_after_blk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_blk_end && !ld_en) |=> !busy && !out_valid);

endmodule

// File: tb/xfer_addr_gen_test.sv
module xfer_addr_gen_test;
    localparam int AW = 32;
    localparam int CW = 16;
    localparam int IW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_en = 1'b0;
    logic [AW-1:0] ld_src_base = '0, ld_dst_base = '0;
    logic [2*CW-1:0] ld_size_count = '0;
    logic [CW-1:0] ld_frames = '0, ld_reload = '0;
    logic [2*IW-1:0] ld_arr_stride = '0, ld_frm_stride = '0;
    logic ld_frame_sync = 1'b0, ld_src_fixed = 1'b0, ld_dst_fixed = 1'b0;
    logic sync_evt = 1'b0, out_ready = 1'b1;
    logic out_valid, out_evt_end, out_blk_end, busy;
    logic [AW-1:0] out_src, out_dst;

    int n_chk = 0;
    int n_bad = 0;

    // test configuration
    logic [31:0] c_sbase, c_dbase;
    int c_acnt, c_bcnt, c_ccnt, c_rld;
    int c_sb, c_db, c_sc, c_dc;
    bit c_ab, c_sfix, c_dfix;

    always #4 clk = ~clk;

    xfer_addr_gen #(.AW(AW), .CW(CW), .IW(IW)) uut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en),
        .ld_src_base(ld_src_base), .ld_dst_base(ld_dst_base),
        .ld_size_count(ld_size_count), .ld_frames(ld_frames),
        .ld_reload(ld_reload), .ld_arr_stride(ld_arr_stride),
        .ld_frm_stride(ld_frm_stride), .ld_frame_sync(ld_frame_sync),
        .ld_src_fixed(ld_src_fixed), .ld_dst_fixed(ld_dst_fixed),
        .sync_evt(sync_evt), .out_ready(out_ready), .out_valid(out_valid),
        .out_src(out_src), .out_dst(out_dst), .out_evt_end(out_evt_end),
        .out_blk_end(out_blk_end), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    task automatic do_load();
        @(negedge clk);
        ld_src_base   = c_sbase;
        ld_dst_base   = c_dbase;
        ld_size_count = {16'(c_bcnt), 16'(c_acnt)};
        ld_frames     = 16'(c_ccnt);
        ld_reload     = 16'(c_rld);
        ld_arr_stride = {16'(c_db), 16'(c_sb)};
        ld_frm_stride = {16'(c_dc), 16'(c_sc)};
        ld_frame_sync = c_ab;
        ld_src_fixed  = c_sfix;
        ld_dst_fixed  = c_dfix;
        ld_en = 1'b1;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic pulse_evt();
        sync_evt = 1'b1;
        @(negedge clk);
        sync_evt = 1'b0;
    endtask

    task automatic wait_valid(input string req);
        int k;
        k = 0;
        while (!out_valid && k < 50) begin
            @(negedge clk);
            k++;
        end
        if (!out_valid) check(1'b0, req, "beat timeout", 0, 1);
    endtask

    // Walks the block by the requirements and compares every beat.
    task automatic run_block(input string req, input bit stall, input bit pend);
        logic [31:0] s_arr, s_frm, d_arr, d_frm, es, ed;
        bit first, owed, stalled;
        int nb;
        first = 1; owed = 0; stalled = 0;
        s_arr = c_sbase; s_frm = c_sbase; d_arr = c_dbase; d_frm = c_dbase;
        do_load();
        check(busy == 1'b1, "R2", "busy after load", busy, 1);
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R2", "valid before event", out_valid, 0);
        for (int c = 0; c < c_ccnt; c++) begin
            nb = (c == 0 || c_ab) ? c_bcnt : c_rld;
            for (int b = 0; b < nb; b++) begin
                for (int a = 0; a < c_acnt; a++) begin
                    bit newev, lastb, eoe, eob;
                    newev = (a == 0) && (!c_ab || b == 0);
                    lastb = (a == c_acnt - 1);
                    eoe = lastb && (!c_ab || b == nb - 1);
                    eob = lastb && (b == nb - 1) && (c == c_ccnt - 1);
                    if (newev) begin
                        if (owed) owed = 0;
                        else begin
                            if (!first) begin
                                @(negedge clk);
                                check(out_valid == 1'b0, req, "valid without event", out_valid, 0);
                            end
                            pulse_evt();
                        end
                        first = 0;
                    end
                    wait_valid(req);
                    es = c_sfix ? c_sbase : s_arr + 32'(a);
                    ed = c_dfix ? c_dbase : d_arr + 32'(a);
                    check(out_src == es, c_sfix ? "R11" : "R3 R4", "src", out_src, es);
                    check(out_dst == ed, "R3 R4", "dst", out_dst, ed);
                    check(out_evt_end == eoe, req, "evt_end", out_evt_end, eoe);
                    check(out_blk_end == eob, "R8", "blk_end", out_blk_end, eob);
                    if (stall && !stalled && a == 1) begin
                        stalled = 1;
                        out_ready = 1'b0;
                        repeat (3) begin
                            @(negedge clk);
                            check(out_valid == 1'b1, "R10", "valid held", out_valid, 1);
                            check(out_src == es && out_dst == ed, "R10", "addr held", out_src, es);
                        end
                        out_ready = 1'b1;
                    end
                    if (pend && newev && c < c_ccnt - 1) begin
                        sync_evt = 1'b1;
                        owed = 1;
                    end
                    @(negedge clk);
                    sync_evt = 1'b0;
                    if (lastb) begin
                        if (b < nb - 1) begin
                            s_arr = s_arr + 32'(c_sb);
                            d_arr = d_arr + 32'(c_db);
                        end else if (c_ab) begin
                            s_frm = s_frm + 32'(c_sc); s_arr = s_frm;
                            d_frm = d_frm + 32'(c_dc); d_arr = d_frm;
                        end else begin
                            s_arr = s_arr + 32'(c_sc); s_frm = s_arr;
                            d_arr = d_arr + 32'(c_dc); d_frm = d_arr;
                        end
                    end
                end
            end
        end
        check(busy == 1'b0, "R8", "busy after block", busy, 0);
        check(out_valid == 1'b0, "R8", "valid after block", out_valid, 0);
        pulse_evt();
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R8", "event after block ignored", out_valid, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid at reset", out_valid, 0);
        check(busy == 1'b0, "R1", "busy at reset", busy, 0);
    endtask

    task automatic t_frame_mode(input bit stall);
        c_sbase = 32'h1000; c_dbase = 32'h8000;
        c_acnt = 3; c_bcnt = 2; c_ccnt = 2; c_rld = 5;
        c_sb = 4; c_db = -8; c_sc = 16; c_dc = 100;
        c_ab = 1; c_sfix = 0; c_dfix = 0;
        run_block(stall ? "R10" : "R5", stall, 0);
    endtask

    task automatic t_array_mode();
        c_sbase = 32'h200; c_dbase = 32'h40;
        c_acnt = 2; c_bcnt = 2; c_ccnt = 3; c_rld = 3;
        c_sb = 8; c_db = 2; c_sc = -32; c_dc = 1000;
        c_ab = 0; c_sfix = 0; c_dfix = 0;
        run_block("R6 R7", 0, 0);
    endtask

    task automatic t_fixed();
        c_sbase = 32'hF000; c_dbase = 32'h300;
        c_acnt = 2; c_bcnt = 2; c_ccnt = 2; c_rld = 1;
        c_sb = 12; c_db = 0; c_sc = 40; c_dc = 0;
        c_ab = 1; c_sfix = 1; c_dfix = 0;
        run_block("R11", 0, 0);
    endtask

    task automatic t_pending();
        c_sbase = 32'h500; c_dbase = 32'h900;
        c_acnt = 2; c_bcnt = 1; c_ccnt = 3; c_rld = 1;
        c_sb = 0; c_db = 0; c_sc = 6; c_dc = -6;
        c_ab = 1; c_sfix = 0; c_dfix = 0;
        run_block("R9", 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_frame_mode(0);
        t_array_mode();
        t_frame_mode(1);
        t_fixed();
        t_pending();
        summary();
    end

endmodule